// File: doc/BRIEF.md
# Secure debug port access controller

This block decides, every cycle, whether an external debugger may reach the on-chip debug access port. It combines the fuse-held security settings, a software debug-enable bit with its own lock, and the state of a port-mode pin into two registered enables. The first, `dbg_en`, gates the debug access port. The second, `test_en`, gates the test-only port. The fuse array and the TAP state machine sit outside the block. The block only produces the two enables.

In the authenticated level, a debugger first reads a 64-bit device-unique challenge from a small word-addressed register window. It then writes a 128-bit response as four 32-bit words and writes to a submit address. The block compares the response against the stored reference. An exact match latches a grant. Any mismatch clears the grant. A grant lasts until the next reset, or until a later submit fails.

The enable decision is resolved in a fixed order, highest priority first:
1. the hard disable fuse,
2. the no-debug level,
3. the software enable (unless the override fuse kills it),
4. the open level,
5. the authenticated level.

Top module: `dbg_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `dbg_en` and `test_en` are 0. Reset clears the latched grant, the software enable bit and its lock.
- R2: When `fuse_disable` is 1, both `dbg_en` and `test_en` are 0, whatever the other inputs and the latched state are.
- R3: When `fuse_mode` is 2'b10 or 2'b11 (no-debug level), `dbg_en` is 0, even if the software enable is set or a grant is latched.
- R4: When `fuse_mode` is 2'b00 (open level) and `fuse_disable` is 0, `dbg_en` equals the inverse of `mode_pin`.
- R5: When `fuse_mode` is 2'b01 (authenticated level), the following holds:
  - The response words are written at addresses 2 to 5, with address 2 holding bits 31:0 and address 5 holding bits 127:96.
  - A write to address 6 submits the response.
  - `dbg_en` rises only after a submit whose response equals `fuse_ref` in all 128 bits.
  - A submit that differs in any single bit clears the grant.
- R6: Bit 0 of the control word at address 7 is the software enable. When it is 1 and `fuse_sw_override` is 0, `dbg_en` is 1 in the open and authenticated levels without any challenge/response.
- R7: When `fuse_sw_override` is 1, the software enable bit has no effect on `dbg_en`.
- R8: Bit 1 of the control word at address 7 is a lock.
  - Writing 1 to it sets the lock, and the lock stays set until reset.
  - While the lock is set, writes cannot change bit 0.
  - A write that sets the lock and bit 0 together takes both.
  - Reading address 7 returns {lock, enable} in bits 1:0.
- R9: When `mode_pin` is 1:
  - `dbg_en` is 0.
  - `test_en` equals the inverse of `fuse_disable`.
  - Register writes are ignored.
  
  When `mode_pin` is 0, `test_en` is 0.
- R10: Reads are combinational.
  - Address 0 returns challenge bits 31:0 and address 1 returns bits 63:32.
  - The response, submit and unused addresses read as 0.
- R11: Both enables are registered. A change on a fuse or on `mode_pin` shows on the enables after one rising clock edge. A register write shows after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_disable | input | 1 | Hard disable of all debug and test access |
| fuse_mode | input | 2 | Security level: 00 open, 01 authenticated, 1x no debug |
| fuse_sw_override | input | 1 | Kills the software enable path |
| fuse_uid | input | UID_W (64) | Device-unique challenge value |
| fuse_ref | input | RESP_W (128) | Stored response reference |
| mode_pin | input | 1 | Port mode: 0 debug port, 1 test-only port |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register word address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data (combinational) |
| dbg_en | output | 1 | Debug access port enable |
| test_en | output | 1 | Test-only port enable |

## Verification
Fuse and pin changes reach the enables one rising edge later. A register write takes two rising edges: one to update the software bit or the grant, and one more through the output register. Read data is due in the same cycle the address is presented. The bench drives every input on a falling edge. It samples the enables at least two falling edges after the last write, and samples reads 1 ns after setting the address. One dedicated check samples exactly one falling edge after a pin change. It first confirms that the old value still holds before that edge, then that the new value appears right after it.

// File: rtl/dbg_gate_pkg.sv
// Package: shared types for the debug access controller.
// Assumes the mode field encoding 00 open, 01 authenticated, 1x no debug.
package dbg_gate_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN = 2'd0,
        LVL_AUTH = 2'd1,
        LVL_NONE = 2'd2,
        LVL_OFF  = 2'd3
    } sec_level_e;

    // Resolve the fuse settings into one security level; the hard disable wins.
    function automatic sec_level_e resolve_level(input logic hard_off, input logic [1:0] mode);
        if (hard_off)          return LVL_OFF;
        else if (mode[1])      return LVL_NONE;
        else if (mode == 2'b00) return LVL_OPEN;
        else                   return LVL_AUTH;
    endfunction

endpackage

// File: rtl/dbg_resp_compare.sv
// Response store and comparator.
// Holds the debugger-supplied response as word registers. On submit, it
// compares all bits at once with the reference: the XOR is reduced in a single
// cycle, so timing does not depend on the data. The grant is set on a match
// and cleared on a mismatch.
// Assumes RESP_W is a multiple of DATA_W.
module dbg_resp_compare #(
    parameter int RESP_W = 128,
    parameter int DATA_W = 32,
    localparam int NWORDS = RESP_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWORDS-1:0] word_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RESP_W-1:0] ref_val,
    input  logic              submit,
    output logic              grant
);

    logic [RESP_W-1:0] resp_q;
    logic              match;

    genvar w;
    generate
        for (w = 0; w < NWORDS; w++) begin : g_word
            // Capture one response word when its write enable is strobed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    resp_q[w*DATA_W +: DATA_W] <= '0;
                else if (word_we[w])
                    resp_q[w*DATA_W +: DATA_W] <= wdata;
            end
        end
    endgenerate

    // Full-width equality, evaluated in one pass with no early exit.
    assign match = ~|(resp_q ^ ref_val);

    // Latch the outcome of each submit; reset removes any grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grant <= 1'b0;
        else if (submit)
            grant <= match;
    end

endmodule

// File: rtl/dbg_sw_enable.sv
// Software debug-enable bit with a sticky lock.
// Once the lock is set, the enable bit is frozen until reset. A single write
// may set the lock and the enable together.
module dbg_sw_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wr_enable,
    input  logic wr_lock,
    output logic en_q,
    output logic lock_q
);

    // Update the enable unless locked; the lock only ever sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lock_q <= 1'b0;
        end else if (we) begin
            lock_q <= lock_q | wr_lock;
            if (!lock_q)
                en_q <= wr_enable;
        end
    end

endmodule

// File: rtl/dbg_access_arbiter.sv
// Priority resolution of the port enables.
// Order, highest first: hard disable, no-debug level, software enable (unless
// overridden), open level, authenticated grant. The mode pin selects the debug
// port or the test-only port. Both outputs are registered and are 0 in reset.
module dbg_access_arbiter
    import dbg_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fuse_disable,
    input  logic [1:0] fuse_mode,
    input  logic       fuse_sw_override,
    input  logic       sw_en,
    input  logic       auth_grant,
    input  logic       mode_pin,
    output logic       dbg_en,
    output logic       test_en
);

    sec_level_e level;
    logic       sw_path;
    logic       allow;

    assign level   = resolve_level(fuse_disable, fuse_mode);
    assign sw_path = sw_en && !fuse_sw_override;

    // Decide whether the debug port may open at the current level.
    always_comb begin
        unique case (level)
            LVL_OFF, LVL_NONE: allow = 1'b0;
            LVL_OPEN:          allow = 1'b1;
            LVL_AUTH:          allow = sw_path || auth_grant;
            default:           allow = 1'b0;
        endcase
    end

    // Register both enables so the outputs are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_en  <= 1'b0;
            test_en <= 1'b0;
        end else begin
            dbg_en  <= allow && !mode_pin;
            test_en <= mode_pin && (level != LVL_OFF);
        end
    end

endmodule

// File: rtl/dbg_gate_ctrl.sv
// Top of the debug access controller.
// Word-addressed register window:
//   - challenge words first,
//   - then the response words,
//   - then the submit address,
//   - then the control word {lock, enable}.
// Writes are accepted only while the mode pin selects the debug port.
// Assumes UID_W and RESP_W are multiples of DATA_W and the map fits ADDR_W.
module dbg_gate_ctrl #(
    parameter int UID_W  = 64,
    parameter int RESP_W = 128,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_disable,
    input  logic [1:0]        fuse_mode,
    input  logic              fuse_sw_override,
    input  logic [UID_W-1:0]  fuse_uid,
    input  logic [RESP_W-1:0] fuse_ref,
    input  logic              mode_pin,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dbg_en,
    output logic              test_en
);

    localparam int UID_WORDS   = UID_W / DATA_W;
    localparam int RESP_WORDS  = RESP_W / DATA_W;
    localparam int RESP_BASE   = UID_WORDS;
    localparam int SUBMIT_ADDR = RESP_BASE + RESP_WORDS;
    localparam int CTRL_ADDR   = SUBMIT_ADDR + 1;

    logic                  wr_ok;
    logic [RESP_WORDS-1:0] resp_we;
    logic                  submit;
    logic                  ctrl_we;
    logic                  sw_en_q;
    logic                  sw_lock_q;
    logic                  auth_grant;

    assign wr_ok   = reg_wr && !mode_pin;
    assign submit  = wr_ok && (reg_addr == ADDR_W'(SUBMIT_ADDR));
    assign ctrl_we = wr_ok && (reg_addr == ADDR_W'(CTRL_ADDR));

    genvar w;
    generate
        for (w = 0; w < RESP_WORDS; w++) begin : g_we
            assign resp_we[w] = wr_ok && (reg_addr == ADDR_W'(RESP_BASE + w));
        end
    endgenerate

    // Read mux: challenge words and the control word; all else reads zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < UID_WORDS; i++) begin
            if (reg_addr == ADDR_W'(i))
                reg_rdata = fuse_uid[i*DATA_W +: DATA_W];
        end
        if (reg_addr == ADDR_W'(CTRL_ADDR))
            reg_rdata = {{(DATA_W-2){1'b0}}, sw_lock_q, sw_en_q};
    end

    dbg_resp_compare #(
        .RESP_W (RESP_W),
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_we (resp_we),
        .wdata   (reg_wdata),
        .ref_val (fuse_ref),
        .submit  (submit),
        .grant   (auth_grant)
    );

    dbg_sw_enable u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctrl_we),
        .wr_enable (reg_wdata[0]),
        .wr_lock   (reg_wdata[1]),
        .en_q      (sw_en_q),
        .lock_q    (sw_lock_q)
    );

    dbg_access_arbiter u_arb (
        .clk              (clk),
        .rst_n            (rst_n),
        .fuse_disable     (fuse_disable),
        .fuse_mode        (fuse_mode),
        .fuse_sw_override (fuse_sw_override),
        .sw_en            (sw_en_q),
        .auth_grant       (auth_grant),
        .mode_pin         (mode_pin),
        .dbg_en           (dbg_en),
        .test_en          (test_en)
    );

endmodule

// File: rtl/dbg_gate_ctrl_chk.sv
// Checker for the debug access controller, bound into the top module.
// Relates the enables to the fuse, pin and latched state one edge earlier.
module dbg_gate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fuse_disable,
    input logic [1:0] fuse_mode,
    input logic       fuse_sw_override,
    input logic       mode_pin,
    input logic       sw_en_q,
    input logic       sw_lock_q,
    input logic       auth_grant,
    input logic       submit,
    input logic       dbg_en,
    input logic       test_en
);

    assert_disable_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_disable |=> (!dbg_en && !test_en));

    assert_nodebug_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fuse_disable && fuse_mode[1]) |=> !dbg_en);

    assert_open_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fuse_disable && fuse_mode == 2'b00) |=> (dbg_en == !$past(mode_pin)));

    assert_grant_needs_submit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auth_grant) |-> $past(submit));

    assert_override_kills_sw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_sw_override && fuse_mode == 2'b01 && !auth_grant) |=> !dbg_en);

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_lock_q |=> (sw_lock_q && $stable(sw_en_q)));

    assert_pin_selects_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pin |=> (!dbg_en && (test_en == !$past(fuse_disable))));

    assert_pin_blocks_submit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pin |-> !submit);

endmodule

bind dbg_gate_ctrl dbg_gate_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fuse_disable     (fuse_disable),
    .fuse_mode        (fuse_mode),
    .fuse_sw_override (fuse_sw_override),
    .mode_pin         (mode_pin),
    .sw_en_q          (sw_en_q),
    .sw_lock_q        (sw_lock_q),
    .auth_grant       (auth_grant),
    .submit           (submit),
    .dbg_en           (dbg_en),
    .test_en          (test_en)
);

// File: tb/dbg_gate_ctrl_test.sv
// Bench: sweeps every fuse/pin/software/grant combination and flips every
// response bit. Expected enables are computed from the requirement formulas.
module dbg_gate_ctrl_test;

    localparam logic [63:0]  UID = 64'h5A3C_96E1_0F7B_2D48;
    localparam logic [127:0] REF = 128'hC3A5_1E77_0B9D_4F21_8E60_D2B4_7A19_35FC;
    localparam logic [2:0] A_RESP = 3'd2, A_SUBMIT = 3'd6, A_CTRL = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fuse_disable = 1'b0;
    logic [1:0]  fuse_mode = 2'b00;
    logic        fuse_sw_override = 1'b0;
    logic        mode_pin = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_en, test_en;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    dbg_gate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fuse_disable(fuse_disable), .fuse_mode(fuse_mode),
        .fuse_sw_override(fuse_sw_override), .fuse_uid(UID), .fuse_ref(REF),
        .mode_pin(mode_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_en(dbg_en), .test_en(test_en)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic load_resp(input logic [127:0] v);
        for (int i = 0; i < 4; i++) wr(A_RESP + 3'(i), v[i*32 +: 32]);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 dbg_en in reset", {31'b0, dbg_en}, 32'd0);
        check("R1 test_en in reset", {31'b0, test_en}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic settle;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with the open level and pin low still holds enables at 0.
        do_reset();

        // R10: challenge words and zero reads.
        rd_check("R10 challenge low", 3'd0, UID[31:0]);
        rd_check("R10 challenge high", 3'd1, UID[63:32]);
        load_resp(REF);
        for (int a = 2; a <= 6; a++) rd_check("R10 write-only reads zero", 3'(a), 32'd0);
        rd_check("R1 control after reset", A_CTRL, 32'd0);

        // R2..R7, R9: sweep all level, override, software, grant and pin combinations.
        for (int c = 0; c < 128; c++) begin
            logic dis, ovr, sw, pin, au, exp_d, exp_t;
            logic [1:0] md;
            dis = c[0]; md = 2'(c >> 1); ovr = c[3]; sw = c[4]; pin = c[5]; au = c[6];
            fuse_disable = dis; fuse_mode = md; fuse_sw_override = ovr; mode_pin = 1'b0;
            do_reset();
            if (sw) wr(A_CTRL, 32'd1);
            if (au) begin load_resp(REF); wr(A_SUBMIT, 32'd0); end
            mode_pin = pin;
            settle();
            exp_d = !dis && !md[1] && !pin &&
                    ((sw && !ovr) || md == 2'b00 || (md == 2'b01 && au));
            exp_t = pin && !dis;
            check("R2/R3/R4/R5/R6/R7 dbg_en sweep", {31'b0, dbg_en}, {31'b0, exp_d});
            check("R9 test_en sweep", {31'b0, test_en}, {31'b0, exp_t});
        end

        // R5: every single-bit mismatch clears the grant; a match restores it.
        fuse_disable = 0; fuse_mode = 2'b01; fuse_sw_override = 0; mode_pin = 0;
        do_reset();
        load_resp(REF);
        for (int b = 0; b < 128; b++) begin
            logic [127:0] bad;
            bad = REF ^ (128'd1 << b);
            wr(A_RESP + 3'(b / 32), bad[(b/32)*32 +: 32]);
            wr(A_SUBMIT, 32'd0);
            settle();
            check("R5 one-bit mismatch denies", {31'b0, dbg_en}, 32'd0);
            wr(A_RESP + 3'(b / 32), REF[(b/32)*32 +: 32]);
            wr(A_SUBMIT, 32'd0);
            settle();
            check("R5 exact match grants", {31'b0, dbg_en}, 32'd1);
        end

        // R1: reset removes the grant.
        do_reset();
        settle();
        check("R1 grant cleared by reset", {31'b0, dbg_en}, 32'd0);

        // R9: writes while the pin is high are ignored (submit and control).
        mode_pin = 1;
        load_resp(REF);
        wr(A_SUBMIT, 32'd0);
        wr(A_CTRL, 32'd1);
        mode_pin = 0;
        settle();
        check("R9 submit ignored with pin high", {31'b0, dbg_en}, 32'd0);
        rd_check("R9 control write ignored with pin high", A_CTRL, 32'd0);

        // R8: lock and enable set together, then frozen.
        wr(A_CTRL, 32'd3);
        rd_check("R8 lock with enable", A_CTRL, 32'd3);
        wr(A_CTRL, 32'd0);
        rd_check("R8 enable frozen by lock", A_CTRL, 32'd3);
        settle();
        check("R6 locked software enable opens", {31'b0, dbg_en}, 32'd1);
        do_reset();
        rd_check("R8 lock cleared by reset", A_CTRL, 32'd0);
        wr(A_CTRL, 32'd2);
        wr(A_CTRL, 32'd1);
        rd_check("R8 lock alone freezes zero", A_CTRL, 32'd2);

        // R11: a pin change reaches the enables after exactly one edge.
        fuse_mode = 2'b00;
        settle();
        check("R4 open level", {31'b0, dbg_en}, 32'd1);
        mode_pin = 1;
        #1;
        check("R11 dbg_en holds before edge", {31'b0, dbg_en}, 32'd1);
        @(negedge clk);
        check("R11 dbg_en after one edge", {31'b0, dbg_en}, 32'd0);
        check("R11 test_en after one edge", {31'b0, test_en}, 32'd1);

        // R11: a control write shows after two edges.
        fuse_mode = 2'b01; mode_pin = 0;
        do_reset();
        settle();
        @(negedge clk);
        reg_wr = 1; reg_addr = A_CTRL; reg_wdata = 32'd1;
        @(negedge clk);
        reg_wr = 0;
        check("R11 write not yet visible", {31'b0, dbg_en}, 32'd0);
        @(negedge clk);
        check("R11 write visible after two edges", {31'b0, dbg_en}, 32'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule